// File: doc/BRIEF.md
# Serial EEPROM Identification Loader

After reset this block fetches three 16-bit identification words from a serial EEPROM with a three-wire, word-organised read protocol. The words are the vendor ID, the subsystem vendor ID and the model number, and they go into configuration registers. The EEPROM serial clock comes from dividing the system clock. Chip select and serial data out are driven by the block, and serial data in is sampled on the rising edge of the serial clock.

Before any read starts, the block releases the chip-select pin for one cycle and senses its level. The pin has an external pull-up, so a high level shows that an EEPROM is present. If none is found, the registers keep their built-in defaults and loading ends at once.

Once loading is over, a small host register takes direct bit-level control of the serial clock, chip-select and data-out pins. Reading that register also returns the live level of the data-in pin. The configuration outputs show defaults until the busy flag clears, so a host that reads during loading sees defaults.

Top module: `eeprom_id_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o is 1, ee_cs_oe_o is 0 (chip-select pin released for sensing) and the ID outputs show their defaults. A high ee_cs_i in that first cycle marks the EEPROM present, and present_o becomes 1 from the next cycle on.
- R2: During loading, ee_sk_o runs with a period of exactly CLK_DIV clocks, high for CLK_DIV/2 and low for CLK_DIV/2.
- R3: Every word read starts with ee_cs_o rising. Then come a start bit 1, the read opcode bits 1 and 0, and the ADDR_W-bit word address MSB first on ee_di_o, one bit per serial clock. ee_di_o changes only when ee_sk_o falls or ee_cs_o rises, so it is stable at every rising edge.
- R4: After the 3+ADDR_W command bits, the block samples ee_do_i on 1+DATA_W further rising edges. It discards the first sample (dummy 0) and keeps the other DATA_W samples MSB first. The word at address WORD_BASE goes to vendor_id_o, WORD_BASE+1 to subsys_id_o and WORD_BASE+2 to model_id_o.
- R5: Between two word reads, ee_cs_o stays low for at least CLK_DIV clocks.
- R6: The ID outputs hold their defaults for as long as busy_o is 1. All three take their loaded values in the same cycle that busy_o falls.
- R7: If ee_cs_i is low in the sensing cycle, busy_o falls one clock after reset release, present_o is 0, the defaults remain, and ee_sk_o does not pulse. Once busy_o has cleared, it stays clear until the next reset.
- R8: man_wr_i has no effect while busy_o is 1. Afterwards, a write of man_wdata_i (bit0 serial clock, bit1 chip select, bit2 data out) shows on ee_sk_o, ee_cs_o and ee_di_o from the next cycle. man_rdata_o reads {ee_do_i, data out, chip select, serial clock}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_cs_i | input | 1 | Sensed level of the chip-select pin |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| man_wr_i | input | 1 | Write strobe for the manual pin register |
| man_wdata_i | input | 3 | Manual pin values {data out, chip select, clock} |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_cs_oe_o | output | 1 | Drive enable for the chip-select pin |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| man_rdata_o | output | 4 | Manual register readback with live data-in |
| vendor_id_o | output | DATA_W | Vendor ID |
| subsys_id_o | output | DATA_W | Subsystem vendor ID |
| model_id_o | output | DATA_W | Model number |
| busy_o | output | 1 | Automatic load in progress |
| present_o | output | 1 | EEPROM detected at reset |

## Verification
The bench builds the block with CLK_DIV=8 instead of 256. This makes a complete three-word load take about 700 clocks, so both the load and the absent-device case fit in one short run with exact serial-clock period and gap timing still checked. WORD_BASE=5 makes the address bits non-zero, so an address shifted out in the wrong order or off by one bit does not match the word the EEPROM model expects. The model answers only well-formed read commands and checks each command it receives.

// File: rtl/eeprom_ldr_pkg.sv
package eeprom_ldr_pkg;
  localparam int unsigned ID_WORDS = 3;
  // start bit followed by read opcode
  localparam logic [2:0] READ_CMD = 3'b110;

  typedef enum logic [1:0] {CTL_SENSE, CTL_LOAD, CTL_DONE} ctl_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_phase_e;
endpackage

// File: rtl/ee_sk_divider.sv
module ee_sk_divider #(
  parameter int unsigned HALF = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i || wrap) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF > 1) begin : g_tick_chk
      // R2
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import eeprom_ldr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tick_i,
  input  logic              do_i,
  output logic              sk_o,
  output logic              cs_o,
  output logic              di_o,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CMD_W = 3 + ADDR_W;
  localparam int unsigned TOTAL = CMD_W + 1 + DATA_W;
  localparam int unsigned CYC_W = $clog2(TOTAL);

  rd_phase_e         phase_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] sh_q;
  logic              sk_q, cs_q, di_q, gap_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= RD_IDLE;
      cyc_q   <= '0;
      cmd_q   <= '0;
      sh_q    <= '0;
      sk_q    <= 1'b0;
      cs_q    <= 1'b0;
      di_q    <= 1'b0;
      gap_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        RD_IDLE: if (start_i) begin
          phase_q <= RD_SHIFT;
          cs_q    <= 1'b1;
          sk_q    <= 1'b0;
          cmd_q   <= {READ_CMD, addr_i};
          di_q    <= READ_CMD[2];
          cyc_q   <= '0;
        end
        RD_SHIFT: if (tick_i) begin
          if (!sk_q) begin
            sk_q <= 1'b1;
            // capture on rising edge; dummy bit falls off the top
            if (cyc_q >= CYC_W'(CMD_W)) sh_q <= {sh_q[DATA_W-2:0], do_i};
          end else begin
            sk_q <= 1'b0;
            if (cyc_q == CYC_W'(TOTAL - 1)) begin
              cs_q    <= 1'b0;
              di_q    <= 1'b0;
              gap_q   <= 1'b0;
              phase_q <= RD_GAP;
            end else begin
              cyc_q <= cyc_q + 1'b1;
              di_q  <= cmd_q[CMD_W-2];
              cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
            end
          end
        end
        RD_GAP: if (tick_i) begin
          gap_q <= 1'b1;
          if (gap_q) begin
            phase_q <= RD_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= RD_IDLE;
      endcase
    end
  end

  assign sk_o     = sk_q;
  assign cs_o     = cs_q;
  assign di_o     = di_q;
  assign active_o = (phase_q != RD_IDLE);
  assign done_o   = done_q;
  assign data_o   = sh_q;

  // R3
  di_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(di_q) |-> ($fell(sk_q) || $rose(cs_q)));
endmodule

// File: rtl/ee_load_ctrl.sv
module ee_load_ctrl
  import eeprom_ldr_pkg::*;
#(
  parameter int unsigned                   ADDR_W     = 6,
  parameter int unsigned                   DATA_W     = 16,
  parameter int unsigned                   WORD_BASE  = 0,
  parameter logic [ID_WORDS*DATA_W-1:0]    ID_DEFAULT = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_sense_i,
  input  logic                       rd_done_i,
  input  logic [DATA_W-1:0]          rd_data_i,
  output logic                       rd_start_o,
  output logic [ADDR_W-1:0]          rd_addr_o,
  output logic                       sensing_o,
  output logic                       busy_o,
  output logic                       present_o,
  output logic [ID_WORDS*DATA_W-1:0] ids_o
);
  localparam int unsigned IDX_W = $clog2(ID_WORDS);

  ctl_state_e                       state_q;
  logic [IDX_W-1:0]                 idx_q;
  logic                             start_q, present_q;
  logic [ID_WORDS-1:0][DATA_W-1:0]  shadow_q, shadow_nx, ids_q;

  always_comb begin
    shadow_nx        = shadow_q;
    shadow_nx[idx_q] = rd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CTL_SENSE;
      idx_q     <= '0;
      start_q   <= 1'b0;
      present_q <= 1'b0;
      shadow_q  <= ID_DEFAULT;
      ids_q     <= ID_DEFAULT;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        CTL_SENSE: begin
          present_q <= cs_sense_i;
          if (cs_sense_i) begin
            state_q <= CTL_LOAD;
            start_q <= 1'b1;
          end else begin
            state_q <= CTL_DONE;
          end
        end
        CTL_LOAD: if (rd_done_i) begin
          shadow_q <= shadow_nx;
          if (idx_q == IDX_W'(ID_WORDS - 1)) begin
            state_q <= CTL_DONE;
            ids_q   <= shadow_nx;   // publish all words together
          end else begin
            idx_q   <= idx_q + 1'b1;
            start_q <= 1'b1;
          end
        end
        default: state_q <= CTL_DONE;
      endcase
    end
  end

  assign rd_start_o = start_q;
  assign rd_addr_o  = ADDR_W'(WORD_BASE) + ADDR_W'(idx_q);
  assign sensing_o  = (state_q == CTL_SENSE);
  assign busy_o     = (state_q != CTL_DONE);
  assign present_o  = present_q;
  assign ids_o      = ids_q;

  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CTL_DONE) |=> (state_q == CTL_DONE));
  // R6
  ids_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ids_o == ID_DEFAULT));
endmodule

// File: rtl/eeprom_id_loader.sv
module eeprom_id_loader
  import eeprom_ldr_pkg::*;
#(
  parameter int unsigned       CLK_DIV    = 256,
  parameter int unsigned       ADDR_W     = 6,
  parameter int unsigned       DATA_W     = 16,
  parameter int unsigned       WORD_BASE  = 0,
  parameter logic [DATA_W-1:0] VENDOR_DEF = 16'h4E21,
  parameter logic [DATA_W-1:0] SUBSYS_DEF = 16'h4E22,
  parameter logic [DATA_W-1:0] MODEL_DEF  = 16'h0002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ee_cs_i,
  input  logic              ee_do_i,
  input  logic              man_wr_i,
  input  logic [2:0]        man_wdata_i,
  output logic              ee_sk_o,
  output logic              ee_cs_o,
  output logic              ee_cs_oe_o,
  output logic              ee_di_o,
  output logic [3:0]        man_rdata_o,
  output logic [DATA_W-1:0] vendor_id_o,
  output logic [DATA_W-1:0] subsys_id_o,
  output logic [DATA_W-1:0] model_id_o,
  output logic              busy_o,
  output logic              present_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned LW   = $clog2(CLK_DIV + 1);
  localparam logic [ID_WORDS*DATA_W-1:0] ID_DEFAULT = {MODEL_DEF, SUBSYS_DEF, VENDOR_DEF};

  logic                       tick, rd_active, rd_start, rd_done, sensing, busy;
  logic                       rd_sk, rd_cs, rd_di;
  logic [ADDR_W-1:0]          rd_addr;
  logic [DATA_W-1:0]          rd_data;
  logic [ID_WORDS*DATA_W-1:0] ids;
  logic [2:0]                 man_q;  // {di, cs, sk}

  ee_sk_divider #(.HALF(HALF)) i_div (
    .clk_i, .rst_ni, .en_i(rd_active), .tick_o(tick)
  );

  ee_word_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
    .clk_i, .rst_ni,
    .start_i(rd_start), .addr_i(rd_addr), .tick_i(tick), .do_i(ee_do_i),
    .sk_o(rd_sk), .cs_o(rd_cs), .di_o(rd_di),
    .active_o(rd_active), .done_o(rd_done), .data_o(rd_data)
  );

  ee_load_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BASE(WORD_BASE), .ID_DEFAULT(ID_DEFAULT)
  ) i_ctl (
    .clk_i, .rst_ni,
    .cs_sense_i(ee_cs_i), .rd_done_i(rd_done), .rd_data_i(rd_data),
    .rd_start_o(rd_start), .rd_addr_o(rd_addr), .sensing_o(sensing),
    .busy_o(busy), .present_o(present_o), .ids_o(ids)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                man_q <= '0;
    else if (man_wr_i && !busy) man_q <= man_wdata_i;
  end

  assign ee_sk_o     = busy ? rd_sk : man_q[0];
  assign ee_cs_o     = busy ? rd_cs : man_q[1];
  assign ee_di_o     = busy ? rd_di : man_q[2];
  assign ee_cs_oe_o  = !sensing;
  assign man_rdata_o = {ee_do_i, man_q};
  assign busy_o      = busy;
  assign vendor_id_o = ids[0*DATA_W +: DATA_W];
  assign subsys_id_o = ids[1*DATA_W +: DATA_W];
  assign model_id_o  = ids[2*DATA_W +: DATA_W];

  // chip-select low-time counter for the gap check
  logic [LW-1:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               low_cnt <= LW'(CLK_DIV);
    else if (ee_cs_o)                          low_cnt <= '0;
    else if (low_cnt < LW'(CLK_DIV))           low_cnt <= low_cnt + 1'b1;
  end

  // R5
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ee_cs_o) && busy_o) |-> (low_cnt >= LW'(CLK_DIV)));
  // R8
  man_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && $past(man_wr_i)) |->
      ({ee_di_o, ee_cs_o, ee_sk_o} == $past(man_wdata_i)));
endmodule

// File: tb/test_eeprom_id_loader.sv
module test_eeprom_id_loader;
  localparam int unsigned CLK_DIV   = 8;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned WORD_BASE = 5;
  localparam int unsigned PERIOD    = 20;  // 50 MHz at 1 ns units
  localparam logic [15:0] V_DEF = 16'h4E21, S_DEF = 16'h4E22, M_DEF = 16'h0002;
  localparam logic [15:0] ROM [3] = '{16'hA5C3, 16'h13D7, 16'h0F81};
  // {wr, wdata[2:0], ee_do, expected readback[3:0]}
  localparam logic [8:0] MAN_VEC [6] = '{
    {1'b1, 3'b001, 1'b0, 4'b0001},
    {1'b1, 3'b010, 1'b1, 4'b1010},
    {1'b0, 3'b111, 1'b0, 4'b0010},
    {1'b1, 3'b111, 1'b1, 4'b1111},
    {1'b1, 3'b100, 1'b0, 4'b0100},
    {1'b0, 3'b000, 1'b1, 4'b1100}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pull_up = 1'b1, use_force = 1'b0, force_do = 1'b0, mdl_do = 1'b0;
  logic man_wr = 1'b0;
  logic [2:0] man_wdata = '0;
  logic ee_sk, ee_cs, ee_cs_oe, ee_di, busy, present;
  logic ee_cs_pin, ee_do;
  logic [3:0] man_rdata;
  logic [DATA_W-1:0] vendor, subsys, model;

  int n_chk = 0, n_fail = 0;

  assign ee_cs_pin = ee_cs_oe ? ee_cs : pull_up;
  assign ee_do     = use_force ? force_do : mdl_do;

  always #(PERIOD/2) clk = ~clk;

  eeprom_id_loader #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                     .WORD_BASE(WORD_BASE), .VENDOR_DEF(V_DEF),
                     .SUBSYS_DEF(S_DEF), .MODEL_DEF(M_DEF)) i_eeprom_id_loader (
    .clk_i(clk), .rst_ni(rst_n), .ee_cs_i(ee_cs_pin), .ee_do_i(ee_do),
    .man_wr_i(man_wr), .man_wdata_i(man_wdata),
    .ee_sk_o(ee_sk), .ee_cs_o(ee_cs), .ee_cs_oe_o(ee_cs_oe), .ee_di_o(ee_di),
    .man_rdata_o(man_rdata), .vendor_id_o(vendor), .subsys_id_o(subsys),
    .model_id_o(model), .busy_o(busy), .present_o(present)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // EEPROM model
  int rise_n = 0, words_seen = 0, idx = 0;
  logic [8:0] cmd_cap = '0;
  logic [15:0] cur = '0;
  longint t_prev = 0, t_fall = 0;
  bit have_fall = 0;

  always @(negedge ee_cs) if (!use_force) begin
    t_fall = $time;
    have_fall = 1;
  end

  always @(posedge ee_cs) begin
    rise_n = 0;
    if (have_fall && !use_force)
      chk("R5 cs low gap", 32'(($time - t_fall) >= longint'(CLK_DIV * PERIOD)), 32'd1);
  end

  always @(posedge ee_sk) if (ee_cs && !use_force) begin
    rise_n++;
    if (rise_n == 2 && words_seen == 0)
      chk("R2 sk period", 32'($time - t_prev), 32'(CLK_DIV * PERIOD));
    t_prev = $time;
    if (rise_n <= 9) cmd_cap = {cmd_cap[7:0], ee_di};
    if (rise_n == 9) begin
      chk("R3 start and opcode", 32'(cmd_cap[8:6]), 32'b110);
      chk("R4 word address", 32'(cmd_cap[5:0]), 32'(WORD_BASE + words_seen));
      idx = int'(cmd_cap[5:0]) - int'(WORD_BASE);
      cur = (idx >= 0 && idx < 3) ? ROM[idx] : 16'h0000;
      words_seen++;
      #1 mdl_do = 1'b0;
    end else if (rise_n >= 10 && rise_n <= 25) begin
      #1 mdl_do = cur[25-rise_n];
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit early = 0;
    int sk_pulses = 0;
    // reset state
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd1);
    chk("R1 cs released in reset", 32'(ee_cs_oe), 32'd0);
    chk("R1 vendor default", 32'(vendor), 32'(V_DEF));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 present sensed", 32'(present), 32'd1);
    // write attempt while loading
    man_wr = 1'b1; man_wdata = 3'b111;
    @(negedge clk);
    man_wr = 1'b0;
    wait (words_seen == 2);
    @(negedge clk);
    chk("R6 ids default mid-load", 32'({vendor == V_DEF, subsys == S_DEF, model == M_DEF}), 32'b111);
    while (busy) begin
      if (vendor != V_DEF || subsys != S_DEF || model != M_DEF) early = 1;
      @(negedge clk);
    end
    chk("R6 no early id update", 32'(early), 32'd0);
    chk("R4 vendor loaded", 32'(vendor), 32'(ROM[0]));
    chk("R4 subsys loaded", 32'(subsys), 32'(ROM[1]));
    chk("R4 model loaded", 32'(model), 32'(ROM[2]));
    chk("R4 words read", 32'(words_seen), 32'd3);
    chk("R8 busy write ignored", 32'(man_rdata[2:0]), 32'd0);
    chk("R8 pins from register", 32'({ee_di, ee_cs, ee_sk}), 32'd0);

    // manual register vector walk
    use_force = 1'b1;
    foreach (MAN_VEC[i]) begin
      @(negedge clk);
      man_wr = MAN_VEC[i][8]; man_wdata = MAN_VEC[i][7:5]; force_do = MAN_VEC[i][4];
      @(negedge clk);
      man_wr = 1'b0;
      chk("R8 readback", 32'(man_rdata), 32'(MAN_VEC[i][3:0]));
      chk("R8 pins", 32'({ee_di, ee_cs, ee_sk}), 32'(MAN_VEC[i][2:0]));
    end

    // absent device
    pull_up = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 busy cleared", 32'(busy), 32'd0);
    chk("R7 not present", 32'(present), 32'd0);
    chk("R7 defaults kept", 32'({vendor == V_DEF, subsys == S_DEF, model == M_DEF}), 32'b111);
    repeat (4 * CLK_DIV) begin
      @(negedge clk);
      if (ee_sk) sk_pulses++;
    end
    chk("R7 no sk pulses", 32'(sk_pulses), 32'd0);
    chk("R7 busy stays clear", 32'(busy), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule